// File: doc/BRIEF.md
# Coalescing Block Write Buffer

This block sits between a write-through first-level data cache that does not allocate on a store miss and the second-level cache. Every CPU store goes into the buffer, whether or not it hit in the data cache. A store is one word with per-byte enables. The buffer holds a small number of entries, and each entry is one whole cache block with a byte-valid mask. An incoming store is compared against every buffered block. When it finds its block, it is folded into that entry, so a run of stores to one block leaves the buffer as a single transfer.

Entries leave in allocation order through a valid/ready drain port. The port carries the block address, the full block of data, the byte-valid mask and a flag that marks a complete block. Once an entry is offered on the drain port it no longer accepts merges, so the data seen downstream cannot change while it waits. When every entry is in use and a store finds no entry it may merge into, the store is held off by a stall output until an entry drains.

Top module: `coalesce_wbuf`

## Requirements
- R1: After reset the buffer is empty: `dr_valid` is low, and with no store presented `st_stall` is low.
- R2: A store whose block is not present takes a free entry without stalling. The byte in lane b of `st_wdata` (bits 8b+7:8b), when `st_be[b]` is set, lands at block byte index `st_addr[4:2]*4 + b`. In the drain port that byte is `dr_data[8i+7:8i]` with mask bit `dr_mask[i]`.
- R3: A store whose block is held by an entry that is not being drained merges into that entry. The store ORs its enabled bytes into the mask, and a later store to a byte overwrites the earlier value.
- R4: When all four entries are in use and the store cannot merge, `st_stall` is high and the store is not written anywhere.
- R5: Entries are drained in the order in which they were allocated. Each drain handshake (`dr_valid && dr_ready`) frees exactly one entry.
- R6: The oldest entry is offered on the drain port when its block is complete, when more than one entry is occupied, or in a cycle with no store presented. Once offered, address, data and mask stay unchanged until `dr_ready` is seen.
- R7: The entry being offered on the drain port is never a merge target. A store to its block allocates a new entry instead.
- R8: `dr_full` is high exactly when all 32 byte-valid bits of the offered entry are set.
- R9: `dr_addr` equals bits 31:5 of the store address that created the entry.
- R10: A store that matches a non-draining entry is accepted without stall even when every entry is occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store presented this cycle |
| st_addr | input | 32 | Byte address of the store word |
| st_wdata | input | 32 | Store data, lane b in bits 8b+7:8b |
| st_be | input | 4 | Byte enables of the store word |
| st_stall | output | 1 | Store not accepted this cycle; hold it |
| dr_valid | output | 1 | Oldest entry offered to the next level |
| dr_ready | input | 1 | Next level takes the offered entry |
| dr_addr | output | 27 | Block address of the offered entry |
| dr_data | output | 256 | Block data of the offered entry |
| dr_mask | output | 32 | Byte-valid mask of the offered entry |
| dr_full | output | 1 | All bytes of the offered entry valid |

## Verification
The bench uses the default parameters: four entries, 32-byte blocks and 4-byte store words. With these values ten stores are enough to fill every entry, force a stall and then merge into a full buffer. Eight stores complete one block, which brings the full-block drain and the exclusion of a draining entry from merging within a few cycles. Holding the drain ready low lets the bench watch the offered entry stay frozen while later stores to the same block go to a new entry.

// File: rtl/wb_pkg.sv
package wb_pkg;
    localparam int unsigned DEF_ENTRIES     = 4;
    localparam int unsigned DEF_BLOCK_BYTES = 32;
    localparam int unsigned DEF_WORD_BYTES  = 4;
    localparam int unsigned DEF_ADDR_W      = 32;

    typedef logic [7:0] byte_t;
endpackage

// File: rtl/wb_lane_merge.sv
module wb_lane_merge
    import wb_pkg::*;
#(
    parameter int unsigned BLOCK_BYTES = DEF_BLOCK_BYTES,
    parameter int unsigned WORD_BYTES  = DEF_WORD_BYTES,
    localparam int unsigned WORDS      = BLOCK_BYTES / WORD_BYTES,
    localparam int unsigned SEL_W      = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic [BLOCK_BYTES*8-1:0] old_data,
    input  logic [BLOCK_BYTES-1:0]   old_mask,
    input  logic [SEL_W-1:0]         word_sel,
    input  logic [WORD_BYTES*8-1:0]  wdata,
    input  logic [WORD_BYTES-1:0]    be,
    output logic [BLOCK_BYTES*8-1:0] new_data,
    output logic [BLOCK_BYTES-1:0]   new_mask
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
            localparam int unsigned IDX = w * WORD_BYTES + b;
            logic lane_we;
            byte_t lane_new;
            assign lane_we  = (word_sel == SEL_W'(w)) && be[b];
            assign lane_new = wdata[b*8 +: 8];
            assign new_data[IDX*8 +: 8] = lane_we ? lane_new : old_data[IDX*8 +: 8];
            assign new_mask[IDX]        = lane_we | old_mask[IDX];
        end
    end
endmodule

// File: rtl/wb_match.sv
module wb_match #(
    parameter int unsigned N     = 4,
    parameter int unsigned TAG_W = 27,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0][TAG_W-1:0]   tags,
    input  logic [N-1:0]              eligible,
    input  logic [TAG_W-1:0]          probe,
    output logic [N-1:0]              hit_vec,
    output logic                      hit,
    output logic [IDX_W-1:0]          hit_idx
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = eligible[g] && (tags[g] == probe);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    // R3 R7: at most one entry may accept a merge for any block
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/coalesce_wbuf.sv
module coalesce_wbuf
    import wb_pkg::*;
#(
    parameter int unsigned N_ENTRIES   = DEF_ENTRIES,
    parameter int unsigned BLOCK_BYTES = DEF_BLOCK_BYTES,
    parameter int unsigned WORD_BYTES  = DEF_WORD_BYTES,
    parameter int unsigned ADDR_W      = DEF_ADDR_W,
    localparam int unsigned OFF_W   = $clog2(BLOCK_BYTES),
    localparam int unsigned TAG_W   = ADDR_W - OFF_W,
    localparam int unsigned DATA_W  = BLOCK_BYTES * 8,
    localparam int unsigned SW_W    = WORD_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SW_W-1:0]   st_wdata,
    input  logic [WORD_BYTES-1:0] st_be,
    output logic              st_stall,
    output logic              dr_valid,
    input  logic              dr_ready,
    output logic [TAG_W-1:0]  dr_addr,
    output logic [DATA_W-1:0] dr_data,
    output logic [BLOCK_BYTES-1:0] dr_mask,
    output logic              dr_full
);
    localparam int unsigned LANE_W = $clog2(WORD_BYTES);
    localparam int unsigned WSEL_W = (OFF_W > LANE_W) ? OFF_W - LANE_W : 1;
    localparam int unsigned PTR_W  = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
    localparam int unsigned CNT_W  = $clog2(N_ENTRIES + 1);

    typedef struct packed {
        logic [N_ENTRIES-1:0]                   vld;
        logic [N_ENTRIES-1:0][TAG_W-1:0]        tag;
        logic [N_ENTRIES-1:0][BLOCK_BYTES-1:0]  mask;
        logic [N_ENTRIES-1:0][DATA_W-1:0]       data;
        logic [PTR_W-1:0]                       head;
        logic [PTR_W-1:0]                       tail;
        logic [CNT_W-1:0]                       cnt;
        logic                                   draining;
    } wb_state_t;

    wb_state_t state_d, state_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(N_ENTRIES - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Decode of the incoming store
    logic [TAG_W-1:0]  st_tag;
    logic [WSEL_W-1:0] st_word;
    logic              unused_lsb;
    assign st_tag     = st_addr[ADDR_W-1:OFF_W];
    assign st_word    = st_addr[LANE_W +: WSEL_W];
    assign unused_lsb = ^st_addr[LANE_W-1:0];

    // Drain offer and merge eligibility
    logic                 head_vld, head_full, offer, drain_fire;
    logic [N_ENTRIES-1:0] head_onehot, eligible;

    always_comb begin
        head_vld    = state_q.vld[state_q.head];
        head_full   = &state_q.mask[state_q.head];
        head_onehot = N_ENTRIES'(1) << state_q.head;
        offer       = head_vld && (state_q.draining || head_full ||
                                   (state_q.cnt > CNT_W'(1)) || !st_valid);
        drain_fire  = offer && dr_ready;
        eligible    = state_q.vld & ~(offer ? head_onehot : '0);
    end

    // Tag comparison against every entry
    logic [N_ENTRIES-1:0] hit_vec;
    logic                 hit;
    logic [PTR_W-1:0]     hit_idx;

    wb_match #(
        .N     (N_ENTRIES),
        .TAG_W (TAG_W)
    ) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .tags     (state_q.tag),
        .eligible (eligible),
        .probe    (st_tag),
        .hit_vec  (hit_vec),
        .hit      (hit),
        .hit_idx  (hit_idx)
    );

    // Byte merge of the store into its target block
    logic                   has_free, accept;
    logic [PTR_W-1:0]       tgt;
    logic [DATA_W-1:0]      base_data, merged_data;
    logic [BLOCK_BYTES-1:0] base_mask, merged_mask;

    always_comb begin
        has_free  = state_q.cnt < CNT_W'(N_ENTRIES);
        accept    = st_valid && (hit || has_free);
        tgt       = hit ? hit_idx : state_q.tail;
        base_data = hit ? state_q.data[hit_idx] : '0;
        base_mask = hit ? state_q.mask[hit_idx] : '0;
    end

    wb_lane_merge #(
        .BLOCK_BYTES (BLOCK_BYTES),
        .WORD_BYTES  (WORD_BYTES)
    ) u_merge (
        .old_data (base_data),
        .old_mask (base_mask),
        .word_sel (st_word),
        .wdata    (st_wdata),
        .be       (st_be),
        .new_data (merged_data),
        .new_mask (merged_mask)
    );

    // Next state
    always_comb begin
        state_d          = state_q;
        state_d.draining = offer && !dr_ready;

        if (drain_fire) begin
            state_d.vld[state_q.head]  = 1'b0;
            state_d.mask[state_q.head] = '0;
            state_d.head               = ptr_inc(state_q.head);
            state_d.cnt                = state_d.cnt - CNT_W'(1);
        end

        if (accept) begin
            state_d.data[tgt] = merged_data;
            state_d.mask[tgt] = merged_mask;
            if (!hit) begin
                state_d.vld[tgt] = 1'b1;
                state_d.tag[tgt] = st_tag;
                state_d.tail     = ptr_inc(state_q.tail);
                state_d.cnt      = state_d.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // Outputs
    assign st_stall = st_valid && !accept;
    assign dr_valid = offer;
    assign dr_addr  = state_q.tag[state_q.head];
    assign dr_data  = state_q.data[state_q.head];
    assign dr_mask  = state_q.mask[state_q.head];
    assign dr_full  = head_full;

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.cnt <= CNT_W'(N_ENTRIES));

    // R4
    stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall |-> (state_q.cnt == CNT_W'(N_ENTRIES)));

    // R6
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_addr) &&
                                     $stable(dr_mask) && $stable(dr_data)));

    // R2
    alloc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_stall && !hit && !(dr_valid && dr_ready))
        |=> (state_q.cnt == $past(state_q.cnt) + CNT_W'(1)));
endmodule

// File: tb/coalesce_wbuf_test.sv
module coalesce_wbuf_test;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 4;
    localparam int BB = 32;
    localparam int AW = 32;
    localparam int TW = 27;
    localparam int DW = 256;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
        logic        stall;
        logic [1:0]  slot;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 32'h1122_3344, 4'hF, 1'b0, 2'd0},
        '{32'h0000_1004, 32'h5566_7788, 4'hF, 1'b0, 2'd0},
        '{32'h0000_1004, 32'hAABB_CCDD, 4'h3, 1'b0, 2'd0},
        '{32'h0000_2000, 32'h0102_0304, 4'hF, 1'b0, 2'd1},
        '{32'h0000_1008, 32'h0BAD_F00D, 4'hF, 1'b0, 2'd2},
        '{32'h0000_2010, 32'hCAFE_0001, 4'hC, 1'b0, 2'd1},
        '{32'h0000_3000, 32'h9988_7766, 4'hF, 1'b0, 2'd3},
        '{32'h0000_4000, 32'hDEAD_BEEF, 4'hF, 1'b1, 2'd0},
        '{32'h0000_3004, 32'h1234_5678, 4'h6, 1'b0, 2'd3},
        '{32'h0000_1000, 32'h7700_0000, 4'h8, 1'b0, 2'd2}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [31:0]   st_wdata = '0;
    logic [3:0]    st_be = '0;
    logic          st_stall;
    logic          dr_valid;
    logic          dr_ready = 1'b0;
    logic [TW-1:0] dr_addr;
    logic [DW-1:0] dr_data;
    logic [BB-1:0] dr_mask;
    logic          dr_full;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [DW-1:0] rd [NE];
    logic [BB-1:0] rm [NE];
    logic [TW-1:0] rt [NE];

    coalesce_wbuf uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_valid (st_valid),
        .st_addr  (st_addr),
        .st_wdata (st_wdata),
        .st_be    (st_be),
        .st_stall (st_stall),
        .dr_valid (dr_valid),
        .dr_ready (dr_ready),
        .dr_addr  (dr_addr),
        .dr_data  (dr_data),
        .dr_mask  (dr_mask),
        .dr_full  (dr_full)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; st_valid = 1'b0; dr_ready = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < NE; s++) begin
            rd[s] = '0; rm[s] = '0; rt[s] = '0;
        end
    endtask

    task automatic drive(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b);
        st_valid = 1'b1; st_addr = a; st_wdata = d; st_be = b;
    endtask

    // Expected entry contents, built from the byte placement rule (R2, R3)
    task automatic ref_store(input int slot, input logic [31:0] a,
                             input logic [31:0] d, input logic [3:0] b);
        int w;
        w = int'(a[4:2]);
        rt[slot] = a[31:5];
        for (int k = 0; k < 4; k++) begin
            if (b[k]) begin
                rd[slot][(w*4 + k)*8 +: 8] = d[k*8 +: 8];
                rm[slot][w*4 + k] = 1'b1;
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        #2;
        chk("R1", "dr_valid", DW'(dr_valid), DW'(0));
        chk("R1", "st_stall", DW'(st_stall), DW'(0));
        @(negedge clk);

        // Table walk, drain held off
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].addr, VECS[i].data, VECS[i].be);
            #2;
            chk(VECS[i].stall ? "R4" : (i == 8 ? "R10" : "R2"), "st_stall",
                DW'(st_stall), DW'(VECS[i].stall));
            if (i == 2) chk("R6", "dr_valid one entry busy", DW'(dr_valid), DW'(0));
            if (i == 4) begin
                chk("R6", "dr_valid two entries", DW'(dr_valid), DW'(1));
                chk("R9", "dr_addr", DW'(dr_addr), DW'(32'h1000 >> 5));
            end
            @(posedge clk);
            if (!VECS[i].stall) ref_store(int'(VECS[i].slot), VECS[i].addr, VECS[i].data, VECS[i].be);
            @(negedge clk);
        end
        st_valid = 1'b0;
        dr_ready = 1'b1;
        for (int k = 0; k < NE; k++) begin
            #2;
            chk("R5", "dr_valid", DW'(dr_valid), DW'(1));
            chk("R9", "dr_addr", DW'(dr_addr), DW'(rt[k]));
            chk("R3", "dr_data", dr_data, rd[k]);
            chk("R3", "dr_mask", DW'(dr_mask), DW'(rm[k]));
            chk("R8", "dr_full partial", DW'(dr_full), DW'(0));
            step();
        end
        #2;
        chk("R4", "dr_valid after four drains", DW'(dr_valid), DW'(0));
        @(negedge clk);

        // Full block: drain offered while a store arrives; store to it allocates
        do_reset();
        for (int w = 0; w < 8; w++) begin
            drive(32'h5000 + 32'(w*4), 32'hA0A0_A000 + 32'(w), 4'hF);
            #2;
            chk("R3", "st_stall block fill", DW'(st_stall), DW'(0));
            step();
        end
        drive(32'h5000, 32'hFFFF_FFFF, 4'hF);
        #2;
        chk("R6", "dr_valid full block", DW'(dr_valid), DW'(1));
        chk("R8", "dr_full", DW'(dr_full), DW'(1));
        chk("R7", "st_stall", DW'(st_stall), DW'(0));
        step();
        st_valid = 1'b0; dr_ready = 1'b1;
        #2;
        chk("R8", "dr_mask full", DW'(dr_mask), DW'(32'hFFFF_FFFF));
        chk("R7", "draining word0 kept", DW'(dr_data[31:0]), DW'(32'hA0A0_A000));
        chk("R9", "dr_addr", DW'(dr_addr), DW'(32'h5000 >> 5));
        step();
        #2;
        chk("R7", "new entry mask", DW'(dr_mask), DW'(32'h0000_000F));
        chk("R7", "new entry word0", DW'(dr_data[31:0]), DW'(32'hFFFF_FFFF));
        chk("R8", "dr_full partial", DW'(dr_full), DW'(0));
        step();
        #2;
        chk("R5", "empty after drain", DW'(dr_valid), DW'(0));
        @(negedge clk);

        // Idle offer, then hold while stalled downstream
        do_reset();
        drive(32'h6000, 32'h0000_00AB, 4'h1);
        #2;
        chk("R6", "no offer during store", DW'(dr_valid), DW'(0));
        step();
        st_valid = 1'b0;
        #2;
        chk("R6", "offer when idle", DW'(dr_valid), DW'(1));
        chk("R2", "mask one byte", DW'(dr_mask), DW'(1));
        step();
        drive(32'h6000, 32'h0000_00CD, 4'h1);
        #2;
        chk("R7", "st_stall", DW'(st_stall), DW'(0));
        chk("R6", "held byte", DW'(dr_data[7:0]), DW'(8'hAB));
        step();
        st_valid = 1'b0; dr_ready = 1'b1;
        #2;
        chk("R6", "held byte after store", DW'(dr_data[7:0]), DW'(8'hAB));
        step();
        #2;
        chk("R7", "second entry byte", DW'(dr_data[7:0]), DW'(8'hCD));
        chk("R9", "second entry addr", DW'(dr_addr), DW'(32'h6000 >> 5));
        step();
        #2;
        chk("R5", "empty", DW'(dr_valid), DW'(0));

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule